// File: doc/BRIEF.md
# Command Status Ring Writer

This block sits between a command ring and an executing engine. It takes one command at a time from the command ring and starts the engine. It measures how long the engine works on that command in microseconds. When the engine reports completion, the block writes one status entry into a status ring held in an external memory.

Each entry carries the following fields:
- the command number, echoed back;
- the execution time;
- a 2-bit outcome code;
- a timestamp taken in the write cycle;
- a 4-bit pass counter that advances each time the write pointer wraps.

The consumer compares the least significant bit of the pass counter with the value it expects for the current pass. That tells it whether a slot holds a fresh entry, so it never needs to read the producer's pointer.

Commands arrive on a valid/ready stream. `cmd_ready` is high only while the block is idle. A command is taken in any cycle where `cmd_valid` and `cmd_ready` are both high. The producer must hold `cmd_valid` and `cmd_num` steady until that cycle. Time spent waiting for `cmd_ready` is queueing time and is never counted. The engine side and the ring memory port are plain control pins. The memory accepts a write in every cycle where `ring_wr_en` is high.

Entry layout on `ring_wr_data`:

| Bits | Content |
|---|---|
| [15:0] | command number |
| [25:16] | execution time in microseconds |
| [27:26] | outcome code |
| [31:28] | pass counter |
| [63:32] | timestamp |

Top module: `sq_status_writer`

## Requirements
- R1: `cmd_ready` is 1 only in the idle state. When a command is accepted, `exec_start` is 1 for exactly the following cycle. `cmd_ready` then stays 0 until the cycle after the entry for that command is written.
- R2: `exec_num` holds the accepted command number from the `exec_start` cycle onward. Entry bits [15:0] carry that same number, even if `cmd_num` changes after acceptance.
- R3: The execution time, in entry bits [25:16], is the number of cycles with `us_tick`=1 from the `exec_start` cycle through the cycle in which `exec_done` is seen. Ticks in idle, queueing or acceptance cycles are not counted.
- R4: The execution time saturates at 1023 and does not wrap.
- R5: Entry bits [27:26] hold the `exec_status` value present with `exec_done`. The codes are 0 = success, 1 = blocked queue or cache, 2 = failed, 3 = resource blocked.
- R6: When the outcome code is 2 or 3, the execution time field is written as 0.
- R7: Entry bits [63:32] equal `ts_in` in the cycle in which `ring_wr_en` is 1.
- R8: `ring_wr_en` is a single-cycle pulse in the cycle right after `exec_done` is seen while busy. `exec_done` at any other time has no effect.
- R9: Successive writes go to addresses 0, 1, …, RING_DEPTH-1, then back to 0.
- R10: The pass counter in entry bits [31:28] is 0 for the first pass. It increases by 1 with the first write to address 0 after each wrap, and continues from 0 after 15.
- R11: During and after reset, `cmd_ready`=1, `ring_wr_en`=0 and `exec_start`=0. The first write goes to address 0 with pass counter 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered by the command ring |
| cmd_ready | output | 1 | Block is idle and takes the command |
| cmd_num | input | 16 | Number of the offered command |
| exec_start | output | 1 | One-cycle start pulse to the engine |
| exec_num | output | 16 | Number of the command being executed |
| exec_done | input | 1 | Engine finished the current command |
| exec_status | input | 2 | Outcome code, valid with exec_done |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| ts_in | input | 32 | Free-running timestamp |
| ring_wr_en | output | 1 | Status ring write strobe |
| ring_wr_addr | output | $clog2(RING_DEPTH) | Status ring slot |
| ring_wr_data | output | 64 | Status entry |

## Verification
Commands run with random tick densities, busy lengths from 1 to 20 cycles, and random idle gaps in which ticks and stray `exec_done` pulses are driven. An execution time that matches the bench's count therefore shows that only busy-cycle ticks are counted, and that completion outside the busy state is ignored. Directed cases cover a busy length of 1 with and without a tick, a 1100-cycle execution with a tick every cycle (saturation), and outcome codes 2 and 3 with ticks present (time forced to zero). `ts_in` changes in the write cycle itself, which separates a stamp taken at write time from one taken at completion. Enough commands run to wrap the pass counter from 15 back to 0 in an 8-slot ring.

// File: rtl/sq_status_pkg.sv
package sq_status_pkg;
  localparam int NUM_W  = 16;
  localparam int TIME_W = 10;
  localparam int STAT_W = 2;
  localparam int LOOP_W = 4;
  localparam int TS_W   = 32;
  localparam int ENTRY_W = TS_W + LOOP_W + STAT_W + TIME_W + NUM_W;

  typedef enum logic [STAT_W-1:0] {
    OUT_OK       = 2'd0,
    OUT_BLOCKED  = 2'd1,
    OUT_FAILED   = 2'd2,
    OUT_RES_BLKD = 2'd3
  } outcome_e;

  typedef struct packed {
    logic [TS_W-1:0]   stamp;
    logic [LOOP_W-1:0] pass_cnt;
    logic [STAT_W-1:0] outcome;
    logic [TIME_W-1:0] exec_us;
    logic [NUM_W-1:0]  number;
  } status_entry_t;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_BUSY  = 2'd1,
    WS_WRITE = 2'd2
  } wr_state_e;
endpackage

// File: rtl/sq_exec_timer.sv
module sq_exec_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] next_val
);
  localparam logic [W-1:0] MAX_VAL = '1;

  logic [W-1:0] cnt_q;

  // saturating: holds at MAX_VAL instead of rolling over
  always_comb begin
    next_val = cnt_q;
    if (inc && (cnt_q != MAX_VAL)) next_val = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= next_val;
  end
endmodule

// File: rtl/sq_ring_ptr.sv
module sq_ring_ptr #(
  parameter int DEPTH = 8,
  parameter int AW    = 3,
  parameter int LW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] ptr_q,
  output logic [LW-1:0] pass_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pass_q <= '0;
    end else if (adv) begin
      if (ptr_q == LAST) begin
        ptr_q  <= '0;
        pass_q <= pass_q + 1'b1;
      end else begin
        ptr_q  <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sq_entry_pack.sv
module sq_entry_pack
  import sq_status_pkg::*;
#(
  parameter bit ZERO_INVALID = 1'b1
) (
  input  logic [NUM_W-1:0]   number,
  input  logic [TIME_W-1:0]  exec_us,
  input  logic [STAT_W-1:0]  outcome,
  input  logic [LOOP_W-1:0]  pass_cnt,
  input  logic [TS_W-1:0]    stamp,
  output logic [ENTRY_W-1:0] entry
);
  status_entry_t e;
  logic [TIME_W-1:0] time_fld;

  generate
    if (ZERO_INVALID) begin : g_zero
      // codes 2 and 3 carry no valid fields, so the time is cleared
      assign time_fld = outcome[STAT_W-1] ? '0 : exec_us;
    end else begin : g_raw
      assign time_fld = exec_us;
    end
  endgenerate

  always_comb begin
    e.stamp    = stamp;
    e.pass_cnt = pass_cnt;
    e.outcome  = outcome;
    e.exec_us  = time_fld;
    e.number   = number;
  end

  assign entry = e;
endmodule

// File: rtl/sq_status_writer.sv
module sq_status_writer
  import sq_status_pkg::*;
#(
  parameter int RING_DEPTH = 8,
  localparam int ADDR_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [NUM_W-1:0]   cmd_num,
  output logic               exec_start,
  output logic [NUM_W-1:0]   exec_num,
  input  logic               exec_done,
  input  logic [STAT_W-1:0]  exec_status,
  input  logic               us_tick,
  input  logic [TS_W-1:0]    ts_in,
  output logic               ring_wr_en,
  output logic [ADDR_W-1:0]  ring_wr_addr,
  output logic [ENTRY_W-1:0] ring_wr_data
);
  wr_state_e          state_q;
  logic [NUM_W-1:0]   num_q;
  logic [STAT_W-1:0]  outcome_q;
  logic [TIME_W-1:0]  time_q;
  logic               start_q;
  logic [TIME_W-1:0]  tmr_next;
  logic [LOOP_W-1:0]  pass_q;
  logic               accept;
  logic               busy;
  logic               writing;

  assign accept  = cmd_valid && (state_q == WS_IDLE);
  assign busy    = (state_q == WS_BUSY);
  assign writing = (state_q == WS_WRITE);

  sq_exec_timer #(.W(TIME_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .inc      (busy && us_tick),
    .next_val (tmr_next)
  );

  sq_ring_ptr #(.DEPTH(RING_DEPTH), .AW(ADDR_W), .LW(LOOP_W)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (writing),
    .ptr_q  (ring_wr_addr),
    .pass_q (pass_q)
  );

  sq_entry_pack #(.ZERO_INVALID(1'b1)) u_pack (
    .number   (num_q),
    .exec_us  (time_q),
    .outcome  (outcome_q),
    .pass_cnt (pass_q),
    .stamp    (ts_in),
    .entry    (ring_wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WS_IDLE;
      num_q     <= '0;
      outcome_q <= '0;
      time_q    <= '0;
      start_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        WS_IDLE: if (accept) begin
          num_q   <= cmd_num;
          start_q <= 1'b1;
          state_q <= WS_BUSY;
        end
        WS_BUSY: if (exec_done) begin
          outcome_q <= exec_status;
          time_q    <= tmr_next;   // includes a tick in the done cycle
          state_q   <= WS_WRITE;
        end
        WS_WRITE: state_q <= WS_IDLE;
        default:  state_q <= WS_IDLE;
      endcase
    end
  end

  assign cmd_ready  = (state_q == WS_IDLE);
  assign exec_start = start_q;
  assign exec_num   = num_q;
  assign ring_wr_en = writing;
endmodule

// File: rtl/sq_status_writer_chk.sv
module sq_status_writer_chk
  import sq_status_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [NUM_W-1:0]   cmd_num,
  input logic               exec_start,
  input logic [NUM_W-1:0]   exec_num,
  input logic               exec_done,
  input logic               busy,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [ENTRY_W-1:0] wr_data
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  status_entry_t     ent;
  logic              seen_q;
  logic [AW-1:0]     prev_addr_q;
  logic [LOOP_W-1:0] prev_pass_q;
  logic [AW-1:0]     exp_addr;
  logic [LOOP_W-1:0] pass_inc;

  assign ent      = wr_data;
  assign exp_addr = (prev_addr_q == LAST) ? '0 : prev_addr_q + 1'b1;
  assign pass_inc = prev_pass_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      prev_addr_q <= '0;
      prev_pass_q <= '0;
    end else if (wr_en) begin
      seen_q      <= 1'b1;
      prev_addr_q <= wr_addr;
      prev_pass_q <= ent.pass_cnt;
    end
  end

  assert_accept_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> exec_start && !cmd_ready);

  assert_not_ready_writing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !cmd_ready);

  assert_echo_num_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exec_start |-> exec_num == $past(cmd_num));

  assert_entry_num_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ent.number == exec_num);

  assert_invalid_time_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ent.outcome[STAT_W-1] |-> ent.exec_us == '0);

  assert_write_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && exec_done |=> wr_en);

  assert_single_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && seen_q |-> wr_addr == exp_addr);

  assert_pass_bump_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && seen_q && (wr_addr == '0) |-> ent.pass_cnt == pass_inc);

  assert_pass_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && seen_q && (wr_addr != '0) |-> ent.pass_cnt == prev_pass_q);

  assert_first_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !seen_q |-> wr_addr == '0 && ent.pass_cnt == '0);
endmodule

bind sq_status_writer sq_status_writer_chk #(.DEPTH(RING_DEPTH), .AW(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_num    (cmd_num),
  .exec_start (exec_start),
  .exec_num   (exec_num),
  .exec_done  (exec_done),
  .busy       (busy),
  .wr_en      (ring_wr_en),
  .wr_addr    (ring_wr_addr),
  .wr_data    (ring_wr_data)
);

// File: tb/test_sq_status_writer.sv
module test_sq_status_writer;
  import sq_status_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int AW         = $clog2(DEPTH);

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cmd_valid;
  logic               cmd_ready;
  logic [NUM_W-1:0]   cmd_num;
  logic               exec_start;
  logic [NUM_W-1:0]   exec_num;
  logic               exec_done;
  logic [STAT_W-1:0]  exec_status;
  logic               us_tick;
  logic [TS_W-1:0]    ts_in;
  logic               ring_wr_en;
  logic [AW-1:0]      ring_wr_addr;
  logic [ENTRY_W-1:0] ring_wr_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  // bench-side ring model
  int               m_ptr  = 0;
  logic [LOOP_W-1:0] m_pass = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sq_status_writer #(.RING_DEPTH(DEPTH)) i_sq_status_writer (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_num      (cmd_num),
    .exec_start   (exec_start),
    .exec_num     (exec_num),
    .exec_done    (exec_done),
    .exec_status  (exec_status),
    .us_tick      (us_tick),
    .ts_in        (ts_in),
    .ring_wr_en   (ring_wr_en),
    .ring_wr_addr (ring_wr_addr),
    .ring_wr_data (ring_wr_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [TIME_W-1:0] exp_time(input int ticks, input logic [STAT_W-1:0] st);
    if (st[1]) return '0;
    if (ticks > 1023) return 10'd1023;
    return TIME_W'(ticks);
  endfunction

  // One command: idle gap, acceptance, busy phase, write check, return to idle.
  task automatic run_cmd(input logic [NUM_W-1:0] num, input logic [STAT_W-1:0] st,
                         input int busy_len, input int tick_pct, input int gap);
    int ticks = 0;
    status_entry_t e;
    logic [TS_W-1:0] wts;
    for (int g = 0; g < gap; g++) begin
      us_tick     = (($urandom % 100) < tick_pct);
      exec_done   = $urandom;          // stray completion while idle: R8 ignored
      exec_status = $urandom;
      ts_in       = $urandom;
      @(negedge clk);
      check("R8 no write from idle done", ring_wr_en, 1'b0);
    end
    exec_done = 1'b0;
    cmd_valid = 1'b1;
    cmd_num   = num;
    us_tick   = 1'b1;                  // tick in acceptance cycle: R3 excluded
    ts_in     = $urandom;
    @(negedge clk);
    check("R1 start pulse", exec_start, 1'b1);
    check("R1 ready low", cmd_ready, 1'b0);
    check("R2 exec_num", exec_num, num);
    cmd_valid = 1'b0;
    cmd_num   = $urandom;
    for (int b = 0; b < busy_len; b++) begin
      logic t;
      t = (($urandom % 100) < tick_pct);
      us_tick     = t;
      ticks      += int'(t);
      exec_done   = (b == busy_len - 1);
      exec_status = (b == busy_len - 1) ? st : STAT_W'($urandom);
      ts_in       = $urandom;
      @(negedge clk);
      if (b < busy_len - 1) begin
        check("R8 no early write", ring_wr_en, 1'b0);
        check("R1 start single", exec_start, 1'b0);
      end
    end
    exec_done = 1'b0;
    us_tick   = $urandom;
    wts       = $urandom;
    ts_in     = wts;                   // changes inside the write cycle: R7
    #1;
    e = ring_wr_data;
    check("R8 write strobe", ring_wr_en, 1'b1);
    check("R9 address", ring_wr_addr, m_ptr);
    check("R2 entry number", e.number, num);
    check("R3/R4/R6 exec time", e.exec_us, exp_time(ticks, st));
    check("R5 outcome", e.outcome, st);
    check("R10 pass count", e.pass_cnt, m_pass);
    check("R7 stamp", e.stamp, wts);
    check("R1 ready low in write", cmd_ready, 1'b0);
    if (m_ptr == DEPTH - 1) begin m_ptr = 0; m_pass = m_pass + 1'b1; end
    else m_ptr++;
    @(negedge clk);
    check("R8 single pulse", ring_wr_en, 1'b0);
    check("R1 ready back", cmd_ready, 1'b1);
  endtask

  initial begin
    int seed_init;
    seed_init   = $urandom(32'h5EED_0042);
    rst_n       = 1'b0;
    cmd_valid   = 1'b0;
    cmd_num     = '0;
    exec_done   = 1'b0;
    exec_status = '0;
    us_tick     = 1'b0;
    ts_in       = '0;
    repeat (3) @(negedge clk);
    check("R11 reset ready", cmd_ready, 1'b1);
    check("R11 reset wr_en", ring_wr_en, 1'b0);
    check("R11 reset start", exec_start, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 ready after reset", cmd_ready, 1'b1);

    // directed corners
    run_cmd(16'h0001, 2'd0, 1, 100, 0);    // R3 one tick in a single busy cycle
    run_cmd(16'hFFFF, 2'd0, 1, 0, 2);      // R3 no tick
    run_cmd(16'h1234, 2'd0, 1100, 100, 1); // R4 saturation at 1023
    run_cmd(16'h0BAD, 2'd2, 30, 100, 0);   // R6 failed -> time 0
    run_cmd(16'h0C0D, 2'd3, 12, 100, 3);   // R6 resource blocked -> time 0
    run_cmd(16'h00B1, 2'd1, 9, 100, 0);    // R5 blocked keeps time
    run_cmd(16'h8000, 2'd0, 40, 50, 3);    // R3 partial ticks with idle ticks

    // random traffic, enough to wrap the pass counter (R10)
    for (int k = 0; k < 140; k++) begin
      run_cmd(NUM_W'($urandom), STAT_W'($urandom), 1 + ($urandom % 20),
              $urandom % 101, $urandom % 4);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule